// File: doc/BRIEF.md
# Framed Byte SPI Slave with Handshake Bit

This block is an SPI slave that trades single bytes between an external master and two on-chip byte buffers. One buffer holds bytes waiting to go out to the master (the receive side, seen from the host), the other takes bytes the master sends in (the transmit side). Every exchange is one frame, bounded by an active-high select. A frame opens with a direction bit and a register-select bit. Eight data bits follow, most significant first. The frame closes with one handshake bit driven by the slave, which tells the master whether to retry.

The serial clock, select and data input are sampled by the system clock through two-flop synchronisers, and edges are detected on the synchronised copies. The master samples on the serial clock rising edge and the slave changes its output on the falling edge. Each serial clock phase must therefore last at least four system clock cycles. A small status byte reports the buffer flags and two interrupt enables, and an interrupt output combines them.

Top module: `spi_frame_slave`

## Requirements
- R1: A frame runs only while `csIn` is high. The first rising edge of `sclkIn` samples the direction bit (1 = read from slave, 0 = write to slave) and the second samples the register select (0 = data byte, 1 = status byte). Rising edges 3 to 10 carry the data byte MSB first, and the slave drives the handshake bit for rising edge 11. Further rising edges in the same frame have no effect. Lowering `csIn` resets the bit position to the start.
- R2: A data read while `rxValid` is high returns `rxData`. Its MSB is on `misoOut` after the falling edge that follows the register-select bit, and each later bit follows on the next falling edge. The handshake bit is 0, and `rxReady` pulses high for exactly one system clock to consume the byte.
- R3: A data read while `rxValid` is low returns the byte most recently consumed (0 after reset) with handshake bit 1, and `rxReady` stays low.
- R4: A data write while `txReady` is high when the last data bit is sampled raises `txValid` for exactly one system clock, with `txData` equal to the received byte. The handshake bit is 0.
- R5: A data write while `txReady` is low drops the byte, returns handshake bit 1 and leaves `txValid` low.
- R6: A status read returns a byte with bit 0 = NOT `rxValid`, bit 1 = NOT `txReady`, bit 4 = receive interrupt enable, bit 5 = transmit interrupt enable, and all other bits 0. Its handshake bit is 0 and it consumes nothing.
- R7: A status write sets the receive interrupt enable from data bit 4 and the transmit interrupt enable from data bit 5. All other bits are ignored, nothing is pushed, and the handshake bit is 0.
- R8: `irqOut` is high exactly when (receive enable AND `rxValid`) OR (transmit enable AND `txReady`).
- R9: After reset, `misoOut`, `rxReady`, `txValid` and `irqOut` are low and both interrupt enables are 0.
- R10: While `csIn` is low, `misoOut` is low. A frame cut short by `csIn` falling before its last data bit pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the master |
| csIn | input | 1 | Active-high frame select |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| rxData | input | 8 | Head byte of the outbound buffer |
| rxValid | input | 1 | Outbound buffer holds a byte |
| rxReady | output | 1 | One-cycle pulse: head byte consumed |
| txData | output | 8 | Byte written by the master |
| txValid | output | 1 | One-cycle pulse: push `txData` |
| txReady | input | 1 | Inbound buffer has space |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench reads the outbound buffer until it runs dry and then reads once more. A design that popped on an empty read, or that returned fresh-looking data, would show a wrong byte or a 0 handshake bit. It writes with the inbound buffer full, which catches a design that pushes anyway or reports acceptance. It writes 0xFF to the status byte and reads it back, so a design that let reserved bits through would show them. It also cuts a write frame short and then clocks extra edges after a complete frame. These expose a counter that survives select going low, or one that wraps into a second pop.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  // Strobes from the frame controller to the datapath, one system clock each.
  typedef struct packed {
    logic loadRead;    // register-select bit sampled on a read frame
    logic shiftIn;     // a write data bit was sampled
    logic commitWrite; // last write data bit sampled
    logic shiftOut;    // falling edge: present next read data bit
    logic driveFlag;   // falling edge: present handshake bit
    logic clearOut;    // select is low
    logic isRead;      // direction of the current frame
    logic selStatus;   // register select of the current frame
    logic mosiBit;     // synchronised serial input
  } frameStrobes_t;

endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkIn,
  input  logic          csIn,
  input  logic          mosiIn,
  output frameStrobes_t strobes
);

  localparam int FIRST_DATA = 2;
  localparam int LAST_DATA  = DATA_W + 1;
  localparam int FLAG_POS   = DATA_W + 2;
  localparam int FRAME_LEN  = DATA_W + 3;
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic dirReg, selReg;
  logic sclkNow, csNow, mosiNow, riseEv, fallEv;

  // Synchroniser chains, one per input.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '0;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      csSync   <= {csSync[SYNC_STAGES-2:0], csIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
    end
  end

  assign sclkNow = sclkSync[SYNC_STAGES-1];
  assign csNow   = csSync[SYNC_STAGES-1];
  assign mosiNow = mosiSync[SYNC_STAGES-1];
  assign riseEv  = csNow && sclkNow && !sclkPrev;
  assign fallEv  = csNow && !sclkNow && sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      dirReg   <= 1'b0;
      selReg   <= 1'b0;
    end else begin
      sclkPrev <= sclkNow;
      if (!csNow) begin
        bitCnt <= '0;
      end else if (riseEv && bitCnt != CNT_W'(FRAME_LEN)) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(0)) dirReg <= mosiNow;
        if (bitCnt == CNT_W'(1)) selReg <= mosiNow;
      end
    end
  end

  logic inData;
  assign inData = (bitCnt >= CNT_W'(FIRST_DATA)) && (bitCnt <= CNT_W'(LAST_DATA));

  always_comb begin
    strobes             = '0;
    strobes.isRead      = dirReg;
    strobes.selStatus   = (bitCnt == CNT_W'(1)) ? mosiNow : selReg;
    strobes.mosiBit     = mosiNow;
    strobes.clearOut    = !csNow;
    strobes.loadRead    = riseEv && (bitCnt == CNT_W'(1)) && dirReg;
    strobes.shiftIn     = riseEv && inData && !dirReg;
    strobes.commitWrite = riseEv && (bitCnt == CNT_W'(LAST_DATA)) && !dirReg;
    strobes.shiftOut    = fallEv && inData;
    strobes.driveFlag   = fallEv && (bitCnt == CNT_W'(FLAG_POS));
  end

endmodule

// File: rtl/spi_frame_dp.sv
module spi_frame_dp
  import spi_frame_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobes_t     strobes,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              txReady,
  output logic              misoOut,
  output logic              rxReady,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  output logic              irqOut
);

  localparam int RX_EMPTY_BIT = 0;
  localparam int TX_FULL_BIT  = 1;
  localparam int RX_IE_BIT    = 4;
  localparam int TX_IE_BIT    = 5;

  logic [DATA_W-1:0] rdShift, wrShift, lastByte, txDataReg, statusWord, wrWord;
  logic flagReg, misoReg, rxIeReg, txIeReg, rxReadyReg, txValidReg;

  always_comb begin
    statusWord               = '0;
    statusWord[RX_EMPTY_BIT] = !rxValid;
    statusWord[TX_FULL_BIT]  = !txReady;
    statusWord[RX_IE_BIT]    = rxIeReg;
    statusWord[TX_IE_BIT]    = txIeReg;
  end

  assign wrWord = {wrShift[DATA_W-2:0], strobes.mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift    <= '0;
      wrShift    <= '0;
      lastByte   <= '0;
      txDataReg  <= '0;
      flagReg    <= 1'b0;
      misoReg    <= 1'b0;
      rxIeReg    <= 1'b0;
      txIeReg    <= 1'b0;
      rxReadyReg <= 1'b0;
      txValidReg <= 1'b0;
    end else begin
      rxReadyReg <= 1'b0;
      txValidReg <= 1'b0;

      if (strobes.loadRead) begin
        if (strobes.selStatus) begin
          rdShift <= statusWord;
          flagReg <= 1'b0;
        end else if (rxValid) begin
          rdShift    <= rxData;
          lastByte   <= rxData;
          flagReg    <= 1'b0;
          rxReadyReg <= 1'b1;
        end else begin
          rdShift <= lastByte;
          flagReg <= 1'b1;
        end
      end

      if (strobes.shiftIn) wrShift <= wrWord;

      if (strobes.commitWrite) begin
        if (strobes.selStatus) begin
          rxIeReg <= wrWord[RX_IE_BIT];
          txIeReg <= wrWord[TX_IE_BIT];
          flagReg <= 1'b0;
        end else if (txReady) begin
          txDataReg  <= wrWord;
          txValidReg <= 1'b1;
          flagReg    <= 1'b0;
        end else begin
          flagReg <= 1'b1;
        end
      end

      if (strobes.clearOut) begin
        misoReg <= 1'b0;
      end else if (strobes.shiftOut) begin
        misoReg <= strobes.isRead ? rdShift[DATA_W-1] : 1'b0;
        rdShift <= {rdShift[DATA_W-2:0], 1'b0};
      end else if (strobes.driveFlag) begin
        misoReg <= flagReg;
      end
    end
  end

  assign misoOut = misoReg;
  assign rxReady = rxReadyReg;
  assign txValid = txValidReg;
  assign txData  = txDataReg;
  assign irqOut  = (rxIeReg && rxValid) || (txIeReg && txReady);

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frame_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csIn,
  input  logic              mosiIn,
  output logic              misoOut,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              irqOut
);

  frameStrobes_t strobes;

  spi_frame_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .mosiIn(mosiIn),
    .strobes(strobes)
  );

  spi_frame_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rxData(rxData), .rxValid(rxValid), .txReady(txReady),
    .misoOut(misoOut), .rxReady(rxReady), .txData(txData),
    .txValid(txValid), .irqOut(irqOut)
  );

endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk (
  input logic clk,
  input logic rstN,
  input logic csIn,
  input logic misoOut,
  input logic rxValid,
  input logic rxReady,
  input logic txValid,
  input logic txReady
);

  AST_RX_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> rxValid); // R3

  AST_RX_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |=> !rxReady); // R2

  AST_TX_PUSH_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txReady); // R5

  AST_TX_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !txValid); // R4

  AST_ONE_TRANSFER_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxReady, txValid})); // R1

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!csIn && !$past(csIn) && !$past(csIn, 2) && !$past(csIn, 3)) |-> !misoOut); // R10

endmodule

bind spi_frame_slave spi_frame_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .misoOut(misoOut),
  .rxValid(rxValid), .rxReady(rxReady), .txValid(txValid), .txReady(txReady)
);

// File: tb/spi_frame_slave_tb.sv
module spi_frame_slave_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, csIn = 1'b0, mosiIn = 1'b0;
  logic misoOut, rxReady, txValid, irqOut;
  logic [7:0] rxData = 8'h00, txData;
  logic rxValid = 1'b0, txReady = 1'b1;

  int checks = 0, errors = 0, pops = 0, pushes = 0;
  bit done = 0;
  logic [7:0] rxQ[$];
  logic [7:0] expTx[$];

  always #4 clk = ~clk;

  spi_frame_slave u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic refreshRx();
    rxValid = (rxQ.size() != 0);
    rxData  = rxValid ? rxQ[0] : 8'h00;
  endtask

  task automatic pushRx(input logic [7:0] b);
    rxQ.push_back(b);
    refreshRx();
  endtask

  // Outbound buffer model: consume at the handshake edge.
  always @(posedge clk) begin
    if (rxValid && rxReady) begin
      pops++;
      #1;
      void'(rxQ.pop_front());
      refreshRx();
    end
  end

  // Scoreboard monitor for pushes into the inbound buffer.
  always @(negedge clk) begin
    if (txValid && txReady) begin
      pushes++;
      if (expTx.size() == 0) begin
        check(1'b0, "R5 unexpected push", txData, 0);
      end else begin
        logic [7:0] e;
        e = expTx.pop_front();
        check(txData == e, "R4 pushed byte", txData, e);
      end
    end
  end

  // One frame; nRises < 11 cuts it short, > 11 adds extra edges.
  task automatic frame(input bit dir, input bit sel, input logic [7:0] wb,
                       input int nRises, output logic [7:0] rb, output bit flag);
    rb = 8'h00;
    flag = 1'b0;
    @(negedge clk);
    csIn = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nRises; i++) begin
      mosiIn = (i == 0) ? dir : (i == 1) ? sel : (i <= 9) ? wb[9-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 2 && i <= 9) rb[9-i] = misoOut;
      if (i == 10) flag = misoOut;
      sclkIn = 1'b1;
      repeat (HALF) @(negedge clk);
      sclkIn = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csIn = 1'b0;
    mosiIn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic readByte(input bit sel, input logic [7:0] expB, input bit expF,
                          input string tag);
    logic [7:0] rb;
    bit f;
    frame(1'b1, sel, 8'h00, 11, rb, f);
    check(rb == expB, {tag, " byte"}, rb, expB);
    check(f == expF, {tag, " handshake"}, f, expF);
  endtask

  task automatic writeByte(input bit sel, input logic [7:0] wb, input bit expF,
                           input string tag);
    logic [7:0] rb;
    bit f;
    if (!sel && expF == 1'b0) expTx.push_back(wb);
    frame(1'b0, sel, wb, 11, rb, f);
    check(f == expF, {tag, " handshake"}, f, expF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    bit f;
    int p0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    check(misoOut == 0 && rxReady == 0 && txValid == 0 && irqOut == 0,
          "R9 outputs after reset", {misoOut, rxReady, txValid, irqOut}, 0);
    readByte(1'b1, 8'h01, 1'b0, "R9 R6 status empty/space");

    pushRx(8'hA5);
    pushRx(8'h3C);
    txReady = 1'b0;
    readByte(1'b1, 8'h02, 1'b0, "R6 status data/full");
    check(pops == 0, "R6 status read pops nothing", pops, 0);

    readByte(1'b0, 8'hA5, 1'b0, "R2 first read");
    readByte(1'b0, 8'h3C, 1'b0, "R2 second read");
    check(pops == 2, "R2 pop count", pops, 2);
    readByte(1'b0, 8'h3C, 1'b1, "R3 empty read repeats");
    check(pops == 2, "R3 no pop when empty", pops, 2);

    txReady = 1'b1;
    writeByte(1'b0, 8'h5A, 1'b0, "R4 write 5A");
    writeByte(1'b0, 8'hC3, 1'b0, "R4 write C3");
    txReady = 1'b0;
    writeByte(1'b0, 8'h77, 1'b1, "R5 write full");
    check(pushes == 2, "R5 push count", pushes, 2);

    writeByte(1'b1, 8'hFF, 1'b0, "R7 status write FF");
    readByte(1'b1, 8'h33, 1'b0, "R7 status readback");
    check(pushes == 2, "R7 status write pushes nothing", pushes, 2);

    repeat (2) @(negedge clk);
    check(irqOut == 0, "R8 irq off, no conditions", irqOut, 0);
    txReady = 1'b1;
    repeat (2) @(negedge clk);
    check(irqOut == 1, "R8 irq on tx space", irqOut, 1);
    writeByte(1'b1, 8'h10, 1'b0, "R7 status write 10");
    check(irqOut == 0, "R8 irq tx disabled", irqOut, 0);
    pushRx(8'h96);
    @(negedge clk);
    check(irqOut == 1, "R8 irq on rx data", irqOut, 1);

    frame(1'b0, 1'b0, 8'hE1, 6, rb, f);
    check(pushes == 2, "R10 aborted write pushes nothing", pushes, 2);
    check(misoOut == 0, "R10 miso low while idle", misoOut, 0);

    p0 = pops;
    frame(1'b1, 1'b0, 8'h00, 14, rb, f);
    check(rb == 8'h96 && f == 1'b0, "R1 frame with extra edges",
          {rb, 7'b0, f}, {8'h96, 8'h00});
    check(pops == p0 + 1, "R1 single pop despite extra edges", pops, p0 + 1);
    readByte(1'b0, 8'h96, 1'b1, "R1 counter restarts after select");

    repeat (4) @(negedge clk);
    check(expTx.size() == 0, "R4 all expected pushes seen", expTx.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule